// File: doc/BRIEF.md
# Plug-and-Play Unlock Key Detector

This block lives on the card side of a legacy expansion-bus plug-and-play interface. After power-up the card ignores the configuration protocol until it has been unlocked. Unlocking takes a fixed 32-byte sequence written to the configuration address port. The detector watches every write to that port and regenerates the expected key one byte at a time with an 8-bit shift register. When the whole key has arrived in order, it moves the card out of the wait-for-key state and into the sleep state.

The sequence starts with the byte 0x6A. Each following byte is the previous one shifted right by one place, with a new top bit equal to the XOR of the previous byte's two lowest bits. Software makes the detector synchronise by writing 0x00 twice in a row before the key. Any wrong byte abandons the attempt, and the detector then waits for a new zero pair. A neighbouring configuration-control decoder raises `cfg_return` when software asks for a return to wait-for-key. Bus decoding, isolation and the configuration registers are outside this block.

Top module: `pnp_unlock_detect`

## Requirements
- R1: After reset, `in_wait_key` is 1 and `key_hit` is 0. The detector is not synchronised, so a complete key that is not preceded by a zero pair leaves the card in wait-for-key.
- R2: The key is 32 bytes long, the first byte being 0x6A. Each next byte is the current byte shifted right by one, with bit 7 set to bit 0 XOR bit 1 of the current byte. Receiving the whole key after two consecutive 0x00 writes clears `in_wait_key`.
- R3: `key_hit` is high for exactly one cycle, in the cycle after the clock edge that samples the 32nd key byte. `in_wait_key` goes low in that same cycle.
- R4: Synchronisation needs two 0x00 writes with no other address write between them. A single 0x00 write followed by the key does not unlock the card.
- R5: A write that differs from the expected key byte abandons the attempt. Sending the remaining correct bytes afterwards does not unlock the card.
- R6: Two consecutive 0x00 writes at any point, including in the middle of a key or after more than two zeros, restart the match. The next byte is then compared with 0x6A.
- R7: Cycles with `addr_wr` low do not change the match progress, so idle gaps between key bytes are allowed. `key_hit` is never high in a cycle that follows a cycle with no write.
- R8: While the card is out of wait-for-key, address writes have no effect. A zero pair followed by a full key gives no `key_hit`, and `in_wait_key` stays 0.
- R9: A `cfg_return` pulse puts the card back in wait-for-key on the next cycle and clears all match progress. If `cfg_return` arrives in the same cycle as the 32nd key byte, it wins: there is no `key_hit`, and the card stays in wait-for-key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_wr | input | 1 | Write strobe for the configuration address port, one byte per high cycle |
| addr_byte | input | 8 | Byte written to the address port |
| cfg_return | input | 1 | Decoded configuration-control request to return to wait-for-key |
| key_hit | output | 1 | One-cycle pulse when the key completes |
| in_wait_key | output | 1 | 1 while the card is in the wait-for-key state |

## Verification
The hardest case to reach is a key that is wrong at only one position, after every earlier byte has matched. This shows that progress is truly dropped rather than merely stalled. The stimulus therefore sweeps the corrupted position over all 32 byte slots and sends the correct remainder each time. It also sweeps a restart position over every slot, by inserting a zero pair partway through a partial key before a full key. A second narrow case is `cfg_return` landing in the same cycle as the final key byte, which is driven directly.

// File: rtl/pnp_unlock_pkg.sv
package pnp_unlock_pkg;
    typedef enum logic {
        ST_WAIT_KEY = 1'b0,
        ST_SLEEP    = 1'b1
    } card_st_e;

    localparam int          KEY_LEN_DEF  = 32;
    localparam int          BYTE_W_DEF   = 8;
    localparam logic [7:0]  KEY_SEED_DEF = 8'h6A;
endpackage

// File: rtl/pnp_key_lfsr_step.sv
// Combinational next-key-byte generator: shift right, feedback into the top bit.
module pnp_key_lfsr_step #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] cur,
    output logic [BYTE_W-1:0] nxt
);
    for (genvar b = 0; b < BYTE_W - 1; b++) begin : g_shift
        assign nxt[b] = cur[b+1];
    end
    assign nxt[BYTE_W-1] = cur[0] ^ cur[1];
endmodule

// File: rtl/pnp_key_tracker.sv
// Tracks synchronisation and progress through the key; reports completion.
module pnp_key_tracker #(
    parameter int               KEY_LEN  = 32,
    parameter int               BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] KEY_SEED = 8'h6A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic              done
);
    localparam int              IDX_W    = $clog2(KEY_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_LEN - 1);

    typedef struct packed {
        logic              armed;
        logic              zero_seen;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] expect_b;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [BYTE_W-1:0] expect_nxt;
    logic              is_zero;

    pnp_key_lfsr_step #(.BYTE_W(BYTE_W)) i_step (
        .cur (trk_q.expect_b),
        .nxt (expect_nxt)
    );

    assign is_zero = (wr_byte == '0);

    always_comb begin
        trk_d = trk_q;
        done  = 1'b0;
        if (clear) begin
            trk_d.armed     = 1'b0;
            trk_d.zero_seen = 1'b0;
        end else if (wr_en) begin
            if (is_zero && trk_q.zero_seen) begin
                trk_d.armed    = 1'b1;
                trk_d.idx      = '0;
                trk_d.expect_b = KEY_SEED;
            end else if (trk_q.armed && (wr_byte == trk_q.expect_b)) begin
                if (trk_q.idx == LAST_IDX) begin
                    done        = 1'b1;
                    trk_d.armed = 1'b0;
                end else begin
                    trk_d.idx      = trk_q.idx + 1'b1;
                    trk_d.expect_b = expect_nxt;
                end
            end else begin
                trk_d.armed = 1'b0;
            end
            trk_d.zero_seen = is_zero;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{armed: 1'b0, zero_seen: 1'b0, idx: '0, expect_b: KEY_SEED};
        end else begin
            trk_q <= trk_d;
        end
    end
endmodule

// File: rtl/pnp_unlock_detect.sv
// Card-level wait-for-key / sleep state and the key-complete pulse.
module pnp_unlock_detect
    import pnp_unlock_pkg::*;
#(
    parameter int               KEY_LEN  = KEY_LEN_DEF,
    parameter int               BYTE_W   = BYTE_W_DEF,
    parameter logic [BYTE_W-1:0] KEY_SEED = KEY_SEED_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_wr,
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic              cfg_return,
    output logic              key_hit,
    output logic              in_wait_key
);
    typedef struct packed {
        card_st_e st;
        logic     hit;
    } top_t;

    top_t top_d, top_q;
    logic trk_wr;
    logic trk_done;

    assign trk_wr = addr_wr && (top_q.st == ST_WAIT_KEY);

    pnp_key_tracker #(
        .KEY_LEN  (KEY_LEN),
        .BYTE_W   (BYTE_W),
        .KEY_SEED (KEY_SEED)
    ) i_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cfg_return),
        .wr_en   (trk_wr),
        .wr_byte (addr_byte),
        .done    (trk_done)
    );

    always_comb begin
        top_d     = top_q;
        top_d.hit = 1'b0;
        if (cfg_return) begin
            top_d.st = ST_WAIT_KEY;
        end else if (trk_done) begin
            top_d.st  = ST_SLEEP;
            top_d.hit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '{st: ST_WAIT_KEY, hit: 1'b0};
        end else begin
            top_q <= top_d;
        end
    end

    assign key_hit     = top_q.hit;
    assign in_wait_key = (top_q.st == ST_WAIT_KEY);
endmodule

// File: rtl/pnp_unlock_detect_chk.sv
module pnp_unlock_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic addr_wr,
    input logic cfg_return,
    input logic key_hit,
    input logic in_wait_key
);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit |=> !key_hit);

    a_r3_hit_with_exit: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit |-> !in_wait_key);

    a_r2_exit_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_wait_key) |-> key_hit);

    a_r7_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_wr |=> !key_hit);

    a_r8_stay_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_wait_key && !cfg_return) |=> !in_wait_key);

    a_r9_return_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_return |=> (in_wait_key && !key_hit));
endmodule

bind pnp_unlock_detect pnp_unlock_detect_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_wr     (addr_wr),
    .cfg_return  (cfg_return),
    .key_hit     (key_hit),
    .in_wait_key (in_wait_key)
);

// File: tb/test_pnp_unlock_detect.sv
module test_pnp_unlock_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_wr = 1'b0;
    logic [7:0] addr_byte = 8'h00;
    logic       cfg_return = 1'b0;
    logic       key_hit;
    logic       in_wait_key;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] key [32];

    always #4 clk = ~clk;

    pnp_unlock_detect i_pnp_unlock_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_wr     (addr_wr),
        .addr_byte   (addr_byte),
        .cfg_return  (cfg_return),
        .key_hit     (key_hit),
        .in_wait_key (in_wait_key)
    );

    task automatic chk(input string req, input logic act, input logic exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp_v);
        end
    endtask

    // One write; returns at the negedge after the capturing posedge.
    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        addr_wr   = 1'b1;
        addr_byte = b;
        @(negedge clk);
        addr_wr   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic zero_pair();
        wr(8'h00);
        wr(8'h00);
    endtask

    task automatic send_key(input int from_i);
        for (int i = from_i; i < 32; i++) wr(key[i]);
    endtask

    task automatic do_return();
        @(negedge clk);
        cfg_return = 1'b1;
        @(negedge clk);
        cfg_return = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        key[0] = 8'h6A;
        for (int i = 1; i < 32; i++)
            key[i] = {key[i-1][0] ^ key[i-1][1], key[i-1][7:1]};

        idle(3);
        chk("R1 reset in_wait_key", in_wait_key, 1'b1);
        chk("R1 reset key_hit", key_hit, 1'b0);
        rst_n = 1'b1;
        idle(2);

        // R1: key without prior zero pair
        send_key(0);
        chk("R1 unsynced key", in_wait_key, 1'b1);

        // R4: single zero then key
        wr(8'h00);
        send_key(0);
        chk("R4 single zero", in_wait_key, 1'b1);

        // R2, R3, R7: full key with idle gaps
        zero_pair();
        for (int i = 0; i < 32; i++) begin
            wr(key[i]);
            if (i < 31) begin
                chk("R7 no early hit", key_hit, 1'b0);
                idle(i % 3);
            end
        end
        chk("R3 hit after last byte", key_hit, 1'b1);
        chk("R2 left wait-for-key", in_wait_key, 1'b0);
        idle(1);
        chk("R3 hit one cycle", key_hit, 1'b0);

        // R8: writes ignored when unlocked
        zero_pair();
        send_key(0);
        chk("R8 no hit when unlocked", key_hit, 1'b0);
        chk("R8 stays unlocked", in_wait_key, 1'b0);

        // R9: return, then key without zero pair
        do_return();
        chk("R9 back in wait-for-key", in_wait_key, 1'b1);
        send_key(0);
        chk("R9 progress cleared", in_wait_key, 1'b1);

        // R5: corrupt each position, then the correct remainder
        for (int p = 0; p < 32; p++) begin
            zero_pair();
            for (int i = 0; i < p; i++) wr(key[i]);
            wr(key[p] ^ 8'h01);
            send_key(p + 1);
            chk($sformatf("R5 corrupt at %0d", p), in_wait_key, 1'b1);
        end

        // R6: restart in mid key at every position
        for (int p = 1; p < 32; p++) begin
            zero_pair();
            for (int i = 0; i < p; i++) wr(key[i]);
            zero_pair();
            send_key(0);
            chk($sformatf("R6 restart after %0d", p), in_wait_key, 1'b0);
            do_return();
        end

        // R6: three zeros then key
        wr(8'h00);
        zero_pair();
        send_key(0);
        chk("R6 triple zero", in_wait_key, 1'b0);
        do_return();

        // R9: return coincides with 32nd byte
        zero_pair();
        for (int i = 0; i < 31; i++) wr(key[i]);
        @(negedge clk);
        addr_wr    = 1'b1;
        addr_byte  = key[31];
        cfg_return = 1'b1;
        @(negedge clk);
        addr_wr    = 1'b0;
        cfg_return = 1'b0;
        chk("R9 return beats last byte hit", key_hit, 1'b0);
        chk("R9 return beats last byte state", in_wait_key, 1'b1);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule